// File: doc/BRIEF.md
# Fieldbus Automatic Baud Rate Detector

This block sets the receive bit rate of a fieldbus slave by hunting through a fixed list of rates. It drives a rate code to an external UART. Code 0 is the fastest rate, 12 Mbit/s, and each higher code is the next slower rate, down to 9.6 kbit/s. For each received frame the UART reports whether the frame completed without error and which start-delimiter type it carried. The block only uses these per-frame results and never looks at bit timing.

While hunting, the block gives each rate a dwell window counted in system clocks. If a clean frame of an accepted delimiter type arrives in that window, the block locks the current rate and enters the locked state. Otherwise it moves to the next slower rate, and after the slowest rate it wraps back to the fastest. In the locked state a watchdog checks for continued traffic. Every accepted frame restarts the watchdog. If the watchdog runs out, the block goes back to hunting from the fastest rate. The rate code, the state and a one-cycle lock strobe are the block's status outputs.

Top module: `baud_hunt`

## Requirements
- R1: After reset, `state_o` is 2'b00 (hunting), `rate_code_o` is 0 and `lock_stb_o` is low.
- R2: While hunting, a rate code stays on `rate_code_o` for `dwell_cycles_i`+1 clock cycles and then increases by one. Code 0 is 12 Mbit/s and code NUM_RATES-1 (9 by default) is 9.6 kbit/s.
- R3: When the slowest code NUM_RATES-1 times out, the code wraps to 0 and the hunt continues.
- R4: A frame is accepted when `frame_done_i` and `frame_ok_i` are both high and `frame_kind_i` is 2'b00, 2'b01 or 2'b10 (the three accepted delimiter types). An accepted frame while hunting makes `state_o` 2'b01 (locked) one cycle later, and the current rate code is kept.
- R5: While hunting, a frame with `frame_ok_i` low or with `frame_kind_i` = 2'b11 is ignored. It does not lock, and the dwell timing of the rate sequence is unchanged.
- R6: `lock_stb_o` is high for exactly one cycle, in the first cycle of each entry into the locked state. It is low at all other times.
- R7: While locked, `rate_code_o` does not change. If no accepted frame arrives for `wd_cycles_i`+1 cycles after the lock, the block returns to hunting (2'b00) with code 0.
- R8: An accepted frame while locked restarts the watchdog window, so the next `wd_cycles_i`+1 cycles count from that frame.
- R9: `state_o` only ever takes the values 2'b00 or 2'b01, and `rate_code_o` always stays below NUM_RATES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_done_i | input | 1 | UART finished a frame this cycle |
| frame_ok_i | input | 1 | That frame had no error |
| frame_kind_i | input | 2 | Start-delimiter type: 00/01/10 accepted, 11 other |
| dwell_cycles_i | input | 16 | Hunt dwell limit per rate, in clocks |
| wd_cycles_i | input | 16 | Locked-state watchdog limit, in clocks |
| rate_code_o | output | 4 | Rate select to UART, 0 = 12 Mbit/s |
| state_o | output | 2 | 00 hunting, 01 locked |
| lock_stb_o | output | 1 | One-cycle strobe on each lock |

## Verification
The assertions check on every cycle that the state encoding is legal and the rate code is in range. They also check that the lock strobe is single-cycle and appears only on entry to the locked state, that the code is frozen while locked, and that a watchdog expiry lands in hunting with code 0. The exact dwell and watchdog lengths in cycles, the wrap from the slowest rate, the filtering of bad or wrong-type frames, and the watchdog restart on a refreshing frame can only be shown by the bench scenarios. Those scenarios count clock edges against known limit values.

// File: rtl/baud_hunt_pkg.sv
package baud_hunt_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'b00,
    ST_LOCKED = 2'b01
  } hunt_state_e;

  typedef enum logic [1:0] {
    KIND_A     = 2'b00,
    KIND_B     = 2'b01,
    KIND_C     = 2'b10,
    KIND_OTHER = 2'b11
  } frame_kind_e;
endpackage

// File: rtl/rate_stepper.sv
module rate_stepper #(
  parameter int NUM_RATES = 10,
  parameter int CODE_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              restart_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] LastCode = CODE_W'(NUM_RATES - 1);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 code_q <= '0;
    else if (restart_i)          code_q <= '0;
    else if (step_i) begin
      if (code_q == LastCode)    code_q <= '0;
      else                       code_q <= code_q + 1'b1;
    end
  end

  assign code_o = code_q;

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= LastCode); // R9
  AST_WRAP_TO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i && code_q == LastCode) |=> (code_q == '0)); // R3
endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;

  assign hit_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || hit_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_hunt.sv
module baud_hunt
  import baud_hunt_pkg::*;
#(
  parameter int NUM_RATES = 10,
  parameter int CODE_W    = 4,
  parameter int TW        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  input  logic              frame_ok_i,
  input  logic [1:0]        frame_kind_i,
  input  logic [TW-1:0]     dwell_cycles_i,
  input  logic [TW-1:0]     wd_cycles_i,
  output logic [CODE_W-1:0] rate_code_o,
  output logic [1:0]        state_o,
  output logic              lock_stb_o
);
  hunt_state_e state_q, state_d;
  logic        accept, tmr_hit, tmr_clr, step, restart, stb_q;
  logic [TW-1:0] limit;

  assign accept = frame_done_i && frame_ok_i && (frame_kind_i != KIND_OTHER);
  assign limit  = (state_q == ST_HUNT) ? dwell_cycles_i : wd_cycles_i;

  always_comb begin
    state_d = state_q;
    step    = 1'b0;
    restart = 1'b0;
    tmr_clr = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (accept) begin
          state_d = ST_LOCKED;
          tmr_clr = 1'b1;
        end else if (tmr_hit) begin
          step = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (accept) begin
          tmr_clr = 1'b1;
        end else if (tmr_hit) begin
          state_d = ST_HUNT;
          restart = 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= (state_q == ST_HUNT) && (state_d == ST_LOCKED);
    end
  end

  window_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .limit_i (limit),
    .hit_o   (tmr_hit)
  );

  rate_stepper #(.NUM_RATES(NUM_RATES), .CODE_W(CODE_W)) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .restart_i (restart),
    .code_o    (rate_code_o)
  );

  assign state_o    = state_q;
  assign lock_stb_o = stb_q;

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_HUNT) || (state_o == ST_LOCKED)); // R9
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_stb_o |=> !lock_stb_o); // R6
  AST_STB_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT && accept) |=> (lock_stb_o && state_o == ST_LOCKED)); // R6
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED && !(tmr_hit && !accept)) |=> $stable(rate_code_o)); // R7
  AST_WD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED && tmr_hit && !accept)
      |=> (state_o == ST_HUNT && rate_code_o == '0)); // R7
  AST_NO_STB_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED) |=> !lock_stb_o); // R6
endmodule

// File: tb/baud_hunt_tb.sv
`timescale 1ns/1ps
module baud_hunt_tb;
  localparam int DWELL = 3;
  localparam int WD    = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0, ok = 1'b0;
  logic [1:0] kind = 2'b00;
  logic [3:0] code;
  logic [1:0] st;
  logic       stb;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  baud_hunt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_done_i(done), .frame_ok_i(ok),
    .frame_kind_i(kind), .dwell_cycles_i(16'(DWELL)), .wd_cycles_i(16'(WD)),
    .rate_code_o(code), .state_o(st), .lock_stb_o(stb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; done = 1'b0; ok = 1'b0; kind = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic f_ok, input logic [1:0] f_kind);
    done = 1'b1; ok = f_ok; kind = f_kind;
    @(negedge clk);
    done = 1'b0; ok = 1'b0; kind = 2'b00;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", st, 0);
    chk("R1 code", code, 0);
    chk("R1 stb", stb, 0);
  endtask

  task automatic t_step();
    do_reset();
    repeat (DWELL) @(negedge clk);
    chk("R2 still code0", code, 0);
    @(negedge clk);
    chk("R2 code1", code, 1);
    repeat (DWELL + 1) @(negedge clk);
    chk("R2 code2", code, 2);
    chk("R2 state hunt", st, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    repeat ((DWELL + 1) * 9) @(negedge clk);
    chk("R3 slowest", code, 9);
    repeat (DWELL + 1) @(negedge clk);
    chk("R3 wrap", code, 0);
  endtask

  task automatic t_lock();
    do_reset();
    repeat (DWELL + 2) @(negedge clk);
    chk("R4 pre code", code, 1);
    send(1'b1, 2'b01);
    chk("R4 locked", st, 1);
    chk("R4 code kept", code, 1);
    chk("R6 stb high", stb, 1);
    @(negedge clk);
    chk("R6 stb low", stb, 0);
    repeat (3) @(negedge clk);
    chk("R7 code frozen", code, 1);
  endtask

  task automatic t_ignore();
    do_reset();
    send(1'b0, 2'b00);
    chk("R5 bad frame", st, 0);
    send(1'b1, 2'b11);
    chk("R5 other kind", st, 0);
    chk("R5 code", code, 0);
    repeat (2) @(negedge clk);
    chk("R5 timing", code, 1);
    chk("R6 no stb", stb, 0);
  endtask

  task automatic lock_at_two();
    do_reset();
    repeat (2 * (DWELL + 1)) @(negedge clk);
    send(1'b1, 2'b10);
  endtask

  task automatic t_watchdog();
    lock_at_two();
    chk("R4 sd3 locked", st, 1);
    repeat (WD) @(negedge clk);
    chk("R7 still locked", st, 1);
    chk("R7 code2", code, 2);
    @(negedge clk);
    chk("R7 back to hunt", st, 0);
    chk("R7 code reset", code, 0);
  endtask

  task automatic t_refresh();
    lock_at_two();
    repeat (4) @(negedge clk);
    send(1'b1, 2'b00);
    chk("R8 locked", st, 1);
    chk("R6 no stb on refresh", stb, 0);
    repeat (WD) @(negedge clk);
    chk("R8 window restarted", st, 1);
    @(negedge clk);
    chk("R8 expiry", st, 0);
  endtask

  initial begin
    #(5 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_step();
    t_wrap();
    t_lock();
    t_ignore();
    t_watchdog();
    t_refresh();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule